// File: doc/BRIEF.md
# Shadow Configuration Transfer Trigger

This block decides when a configuration that has been loaded in the background into a shadow register bank is copied into the active bank. It does not move any data itself. It emits a single-cycle execute strobe in the master clock domain that the register banks act on. One master clock later it emits a status strobe that can be routed to a pin.

The loader reports the final byte of a configuration stream with a one-cycle `end_byte` pulse. At that moment the block latches the transfer policy from `mode_sel` and `ext_is_arm`. There are three policies:

- **Automatic:** the copy follows at once.
- **Event-driven:** the copy waits for an arm step and then a trigger step. A single asynchronous pin, passed through a two-flop synchronizer and edge detected, stands in for one of the two steps. The end byte or an internal strobe supplies the other.
- **Clock-aligned:** the copy waits for the first cycle in which every internal clock enable is high at once.

An optional pre-trigger gate sits in front of the event trigger. When it is enabled, a pre-trigger strobe must come before the trigger.

Top module: `shadow_xfer_trigger`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `exec_pulse`, `xfer_done` and `armed` are all low.
- R2: Mode code 0 (automatic) makes `exec_pulse` high in the cycle right after the clock edge that samples `end_byte`.
- R3: Mode code 3 is handled exactly as mode code 0.
- R4: Event mode (code 1) with `ext_is_arm`=0: the end byte arms the block, so `armed` is high the next cycle. A rising edge on `ext_pin` then makes `exec_pulse` high after the third rising clock edge that follows the pin change. `int_trig` has no effect in this setting.
- R5: A trigger is ignored when the block is not armed. This covers a pin edge while idle, an `int_trig` in the same cycle as the end byte, and an `int_trig` before the arm step. A pin held high does not trigger again.
- R6: Event mode with `ext_is_arm`=1: the end byte leaves the block waiting for the arm step. A rising edge on `ext_pin` arms it (`armed` high after the third clock edge). An `int_trig` while armed makes `exec_pulse` high in the next cycle.
- R7: With `pretrig_en`=1, a trigger fires only if `pretrig` was sampled while armed on an earlier clock edge. A `pretrig` on the same edge as the trigger leaves that trigger ignored but counts for a later one.
- R8: The pre-trigger record is cleared by each transfer, so the next transfer needs a new `pretrig`.
- R9: Mode code 2 (clock-aligned) fires `exec_pulse` in the cycle after the first clock edge, strictly after the end byte, at which every bit of `clk_en` is 1. Alignment in the end-byte cycle itself does not count.
- R10: `exec_pulse` lasts exactly one cycle, which lies within the allowed one to two cycles. `xfer_done` is high for exactly the cycle after it.
- R11: After a transfer the block is idle and unarmed, and it ignores triggers and alignments until the next end byte.
- R12: An `end_byte` that arrives while a transfer is pending or armed is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Transfer policy, latched at the end byte: 0 automatic, 1 event, 2 clock-aligned, 3 automatic |
| ext_is_arm | input | 1 | Event mode: 1 makes the pin the arm source, 0 makes the pin the trigger |
| end_byte | input | 1 | One-cycle strobe marking the final configuration byte |
| ext_pin | input | 1 | Asynchronous external arm/trigger input |
| int_trig | input | 1 | Internal trigger strobe, used when the pin arms |
| pretrig_en | input | 1 | Requires a pre-trigger before the trigger |
| pretrig | input | 1 | Internal pre-trigger strobe |
| clk_en | input | NUM_EN | Internal clock enables watched in clock-aligned mode |
| exec_pulse | output | 1 | Single-cycle copy command to the register banks |
| xfer_done | output | 1 | Exportable status strobe, one cycle after the copy |
| armed | output | 1 | Block is armed and waiting for its trigger |

## Verification
Two functions can land in the same cycle, and the bench forces both collisions on purpose. The first is a pre-trigger strobe arriving together with the trigger. The bench drives `pretrig` and `int_trig` in the same cycle, expects no `exec_pulse`, and then expects a lone trigger one cycle later to fire. The second is the end byte coinciding with a trigger or with full clock alignment. For this the bench raises `int_trig` and sets `clk_en` to all ones during the end-byte cycle, and judges that nothing fires until a later qualifying event. The clock-aligned sweep rotates through every enable pattern from every starting point and works out arithmetically which cycle fires first.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        XM_AUTO  = 2'd0,
        XM_EVENT = 2'd1,
        XM_ALIGN = 2'd2,
        XM_SPARE = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_ARMED = 2'd2,
        ST_ALIGN = 2'd3
    } xfer_st_e;

    typedef struct packed {
        logic arm;
        logic trig;
    } xfer_evt_t;

    localparam int SYNC_STAGES = 2;

    // The spare code behaves as automatic.
    function automatic xfer_mode_e decode_mode(input logic [1:0] code);
        xfer_mode_e m;
        case (code)
            2'd1:    m = XM_EVENT;
            2'd2:    m = XM_ALIGN;
            default: m = XM_AUTO;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xfer_edge_sync.sv
module xfer_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/xfer_pretrig.sv
module xfer_pretrig (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic armed,
    input  logic pretrig,
    input  logic clear,
    output logic ready
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst || clear || !armed) seen <= 1'b0;
        else if (pretrig)           seen <= 1'b1;
    end

    // With the gate disabled the stage counts as already set.
    assign ready = seen | ~enable;
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import xfer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      end_byte,
    input  logic [1:0] mode_sel,
    input  logic      ext_is_arm,
    input  logic      ext_rise,
    input  logic      int_trig,
    input  logic      pre_ready,
    input  logic      aligned,
    output xfer_st_e  state,
    output logic      fire,
    output logic      exec_q,
    output logic      done_q
);
    xfer_st_e  nxt;
    logic      role_q;
    logic      role_d;
    xfer_evt_t src;

    always_comb begin
        src.arm  = ext_rise;
        src.trig = role_q ? int_trig : ext_rise;
    end

    always_comb begin
        nxt    = state;
        fire   = 1'b0;
        role_d = role_q;
        case (state)
            ST_IDLE: begin
                if (end_byte) begin
                    role_d = ext_is_arm;
                    case (decode_mode(mode_sel))
                        XM_EVENT: nxt  = ext_is_arm ? ST_PEND : ST_ARMED;
                        XM_ALIGN: nxt  = ST_ALIGN;
                        default:  fire = 1'b1;
                    endcase
                end
            end
            ST_PEND: begin
                if (src.arm) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (src.trig && pre_ready) begin
                    fire = 1'b1;
                    nxt  = ST_IDLE;
                end
            end
            ST_ALIGN: begin
                if (aligned) begin
                    fire = 1'b1;
                    nxt  = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            role_q <= 1'b0;
            exec_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            state  <= nxt;
            role_q <= role_d;
            exec_q <= fire;
            done_q <= exec_q;
        end
    end
endmodule

// File: rtl/shadow_xfer_trigger.sv
module shadow_xfer_trigger
    import xfer_pkg::*;
#(
    parameter int NUM_EN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              ext_is_arm,
    input  logic              end_byte,
    input  logic              ext_pin,
    input  logic              int_trig,
    input  logic              pretrig_en,
    input  logic              pretrig,
    input  logic [NUM_EN-1:0] clk_en,
    output logic              exec_pulse,
    output logic              xfer_done,
    output logic              armed
);
    xfer_st_e st;
    logic     ext_rise;
    logic     pre_ready;
    logic     fire;
    logic     aligned;

    assign aligned = &clk_en;

    xfer_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_pin),
        .rise (ext_rise)
    );

    xfer_pretrig u_pre (
        .clk     (clk),
        .rst     (rst),
        .enable  (pretrig_en),
        .armed   (st == ST_ARMED),
        .pretrig (pretrig),
        .clear   (fire),
        .ready   (pre_ready)
    );

    xfer_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .end_byte   (end_byte),
        .mode_sel   (mode_sel),
        .ext_is_arm (ext_is_arm),
        .ext_rise   (ext_rise),
        .int_trig   (int_trig),
        .pre_ready  (pre_ready),
        .aligned    (aligned),
        .state      (st),
        .fire       (fire),
        .exec_q     (exec_pulse),
        .done_q     (xfer_done)
    );

    assign armed = (st == ST_ARMED);
endmodule

// File: rtl/xfer_trigger_chk.sv
module xfer_trigger_chk
    import xfer_pkg::*;
#(
    parameter int NUM_EN = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_sel,
    input logic              end_byte,
    input logic [NUM_EN-1:0] clk_en,
    input logic              exec_pulse,
    input logic              xfer_done,
    input logic              armed,
    input xfer_st_e          st
);
    a_r10_exec_single: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |=> !exec_pulse);

    a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |=> xfer_done);

    a_r10_done_only_after: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> $past(exec_pulse));

    a_r2_auto_fires: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && end_byte && (mode_sel == 2'd0 || mode_sel == 2'd3)) |=> exec_pulse);

    a_r11_unarmed_after: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |-> !armed);

    a_r9_align_fires: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ALIGN && (&clk_en)) |=> exec_pulse);

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !end_byte) |=> !exec_pulse);
endmodule

bind shadow_xfer_trigger xfer_trigger_chk #(.NUM_EN(NUM_EN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .end_byte   (end_byte),
    .clk_en     (clk_en),
    .exec_pulse (exec_pulse),
    .xfer_done  (xfer_done),
    .armed      (armed),
    .st         (st)
);

// File: tb/test_shadow_xfer_trigger.sv
module test_shadow_xfer_trigger;
    localparam int NUM_EN = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        mode_sel;
    logic              ext_is_arm;
    logic              end_byte;
    logic              ext_pin;
    logic              int_trig;
    logic              pretrig_en;
    logic              pretrig;
    logic [NUM_EN-1:0] clk_en;
    logic              exec_pulse;
    logic              xfer_done;
    logic              armed;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    shadow_xfer_trigger #(.NUM_EN(NUM_EN)) i_shadow_xfer_trigger (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .ext_is_arm (ext_is_arm),
        .end_byte   (end_byte),
        .ext_pin    (ext_pin),
        .int_trig   (int_trig),
        .pretrig_en (pretrig_en),
        .pretrig    (pretrig),
        .clk_en     (clk_en),
        .exec_pulse (exec_pulse),
        .xfer_done  (xfer_done),
        .armed      (armed)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic end_pulse(input logic [1:0] m, input logic role);
        mode_sel   = m;
        ext_is_arm = role;
        end_byte   = 1'b1;
        tick();
        end_byte   = 1'b0;
    endtask

    task automatic pin_edge();
        ext_pin = 1'b1;
        tick(3);
    endtask

    task automatic pin_low();
        ext_pin = 1'b0;
        tick(3);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; mode_sel = 2'd0; ext_is_arm = 1'b0; end_byte = 1'b0;
        ext_pin = 1'b0; int_trig = 1'b0; pretrig_en = 1'b0; pretrig = 1'b0;
        clk_en = '0;
        tick(3);
        check("R1 exec in reset", exec_pulse, 1'b0);
        check("R1 done in reset", xfer_done, 1'b0);
        check("R1 armed in reset", armed, 1'b0);
        rst = 1'b0;
        tick();
        check("R1 exec after reset", exec_pulse, 1'b0);
        check("R1 armed after reset", armed, 1'b0);

        // R2 automatic
        end_pulse(2'd0, 1'b0);
        check("R2 auto exec", exec_pulse, 1'b1);
        check("R2 auto not armed", armed, 1'b0);
        check("R10 done not yet", xfer_done, 1'b0);
        tick();
        check("R10 exec one cycle", exec_pulse, 1'b0);
        check("R10 done follows", xfer_done, 1'b1);
        tick();
        check("R10 done one cycle", xfer_done, 1'b0);

        // R3 spare code
        end_pulse(2'd3, 1'b1);
        check("R3 spare behaves auto", exec_pulse, 1'b1);
        tick(2);

        // R4 pin as trigger
        end_pulse(2'd1, 1'b0);
        check("R4 armed by end byte", armed, 1'b1);
        int_trig = 1'b1; tick(); int_trig = 1'b0;
        check("R4 int_trig no effect", exec_pulse, 1'b0);
        check("R4 still armed", armed, 1'b1);
        ext_pin = 1'b1;
        tick(2);
        check("R4 not before third edge", exec_pulse, 1'b0);
        tick();
        check("R4 exec on third edge", exec_pulse, 1'b1);
        check("R11 unarmed at exec", armed, 1'b0);
        tick(4);
        check("R5 held pin no retrigger", exec_pulse, 1'b0);
        pin_low();

        // R5 pin edge while idle
        pin_edge(); tick();
        check("R5 idle pin ignored", exec_pulse, 1'b0);
        check("R5 idle stays unarmed", armed, 1'b0);
        pin_low();

        // R6 pin as arm; trigger with end byte and before arm ignored
        int_trig = 1'b1;
        end_pulse(2'd1, 1'b1);
        int_trig = 1'b0;
        check("R5 trig with end byte ignored", exec_pulse, 1'b0);
        check("R6 waiting not armed", armed, 1'b0);
        int_trig = 1'b1; tick(); int_trig = 1'b0;
        check("R5 trig before arm ignored", exec_pulse, 1'b0);
        ext_pin = 1'b1;
        tick(2);
        check("R6 not armed before third edge", armed, 1'b0);
        tick();
        check("R6 armed by pin", armed, 1'b1);
        // R12 end byte while armed
        end_pulse(2'd0, 1'b0);
        check("R12 busy end byte ignored", exec_pulse, 1'b0);
        check("R12 still armed", armed, 1'b1);
        int_trig = 1'b1; tick(); int_trig = 1'b0;
        check("R6 int trig fires", exec_pulse, 1'b1);
        tick();
        check("R10 done after event", xfer_done, 1'b1);
        pin_low();

        // R11 idle after transfer
        int_trig = 1'b1; tick(); int_trig = 1'b0;
        check("R11 trig after transfer ignored", exec_pulse, 1'b0);

        // R7 pre-trigger gate
        pretrig_en = 1'b1;
        end_pulse(2'd1, 1'b1);
        pin_edge();
        check("R7 armed", armed, 1'b1);
        int_trig = 1'b1; tick(); int_trig = 1'b0;
        check("R7 trig without pretrig ignored", exec_pulse, 1'b0);
        pretrig = 1'b1; int_trig = 1'b1; tick(); pretrig = 1'b0; int_trig = 1'b0;
        check("R7 same-cycle pretrig ignored", exec_pulse, 1'b0);
        int_trig = 1'b1; tick(); int_trig = 1'b0;
        check("R7 trig after pretrig fires", exec_pulse, 1'b1);
        pin_low();

        // R8 record cleared by transfer
        end_pulse(2'd1, 1'b1);
        pin_edge();
        int_trig = 1'b1; tick(); int_trig = 1'b0;
        check("R8 stale pretrig not reused", exec_pulse, 1'b0);
        pretrig = 1'b1; tick(); pretrig = 1'b0;
        int_trig = 1'b1; tick(); int_trig = 1'b0;
        check("R8 new pretrig fires", exec_pulse, 1'b1);
        pin_low();
        pretrig_en = 1'b0;

        // R9 clock-aligned sweep over all rotations
        for (int s = 0; s < 8; s++) begin
            bit fired;
            clk_en = '1;
            end_pulse(2'd2, 1'b0);
            check("R9 alignment at end byte ignored", exec_pulse, 1'b0);
            fired = 1'b0;
            for (int i = 0; i < 10; i++) begin
                bit exp;
                int v;
                v = (s + i) % 8;
                clk_en = NUM_EN'(v);
                tick();
                exp = (v == 7) && !fired;
                check("R9 first alignment fires", exec_pulse, exp);
                check("R9 never armed", armed, 1'b0);
                if (exp) fired = 1'b1;
            end
            clk_en = '0;
            tick(2);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule